// File: doc/BRIEF.md
# Audio Serial Port Master Clock Generator

This block runs on the master clock of an audio ADC serial port operating as clock master. From a speed-mode select, a 256x/384x ratio family select and a ×2 master-clock prescale select, it derives the frame clock (left/right clock, at the sample rate) and the bit clock (at 64 times the sample rate). Everything stays in the master-clock domain: both clocks come from counters and are sampled from registered state. There are no derived clock trees.

Two strobes help downstream serial logic. One is a single-cycle pulse at the start of each bit-clock period, which is the bit-clock falling-edge instant. The other is a pulse at the start of each frame. The configuration inputs are captured once at reset release and again only at frame boundaries, so the clocks never produce a runt pulse.

Top module: `aud_mclk_gen`

## Requirements
- R1: While `rst_ni` is low, `lrck_o`, `sclk_o`, `sclk_fall_o` and `frame_start_o` are all low.
- R2: Speed encoding on `speed_i` is 00 single, 01 double and 10 quad. With `ratio384_i`=0 and `mclk_x2_i`=0, a frame (one `lrck_o` period) lasts 256, 128 or 128 master-clock cycles respectively.
- R3: `ratio384_i`=1 multiplies the frame length by 1.5. Single speed gives 384, double gives 192, and quad gives 192 without `mclk_x2_i`.
- R4: `mclk_x2_i`=1 doubles the frame length in single and double speed. Quad speed always applies the ×2 prescale, so `mclk_x2_i` has no effect there (quad frame is 128 or 192).
- R5: The reserved speed code 11 behaves exactly as single speed.
- R6: The bit-clock period P is the frame length divided by 64. `sclk_o` is low for ceil(P/2) cycles and then high for floor(P/2) cycles. For P=3 this gives low 2 cycles and high 1 cycle.
- R7: Each frame holds exactly 64 bit-clock periods. `lrck_o` is low (left) for the first 32 and high for the last 32, a 50% duty cycle. `lrck_o` changes only in a cycle where `sclk_fall_o` is high.
- R8: `sclk_fall_o` is high for one cycle at the start of every bit-clock period, which is every `sclk_o` high-to-low step. `frame_start_o` is high only together with `sclk_fall_o` on the first period of a frame, while `lrck_o` is low.
- R9: The configuration inputs are sampled at the first clock after reset release and otherwise only at the end of a frame. A change in mid-frame leaves the current frame length unchanged and takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 as single |
| ratio384_i | input | 1 | 1 selects the 384x family, 0 the 256x family |
| mclk_x2_i | input | 1 | 1 selects the ×2 master-clock prescale |
| lrck_o | output | 1 | Frame clock, low for left channel |
| sclk_o | output | 1 | Bit clock, 64 periods per frame |
| sclk_fall_o | output | 1 | One-cycle strobe at each bit-clock falling edge |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |

## Verification
The bench sweeps all 16 combinations of speed code, ratio family and prescale select. For each combination it measures two full frames in master-clock cycles. This separates the even bit-clock periods from the odd P=3 periods. It also shows that quad speed ignores the prescale select and that code 11 aliases single speed. Within each frame it counts bit-clock falls, `lrck_o` high cycles and `sclk_o` high cycles, and checks strobe-to-edge agreement. These counts separate a wrong duty split or a misplaced frame edge from a merely wrong frame length. A mid-frame configuration change shows that the running frame keeps its old length and the next frame takes the new one. Resets held before a run and asserted mid-frame check that all outputs go quiet.

// File: rtl/aud_mclk_pkg.sv
package aud_mclk_pkg;
  parameter int PER_W = 4;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  // master-clock cycles per bit-clock period
  function automatic logic [PER_W-1:0] sclk_period(logic [1:0] spd, logic r384, logic x2);
    int base;
    int pre;
    int p;
    case (speed_e'(spd))
      SPD_DOUBLE: base = 2;
      SPD_QUAD:   base = 1;
      default:    base = 4;
    endcase
    pre = (speed_e'(spd) == SPD_QUAD || x2) ? 2 : 1;
    p = base * pre;
    if (r384) p = (p * 3) / 2;
    return PER_W'(p);
  endfunction
endpackage

// File: rtl/aud_clk_cfg.sv
module aud_clk_cfg
  import aud_mclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [1:0]       speed_i,
  input  logic             ratio384_i,
  input  logic             mclk_x2_i,
  output logic [PER_W-1:0] period_o,
  output logic [PER_W-1:0] lo_len_o
);
  logic [PER_W-1:0] period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     period_q <= PER_W'(4);
    else if (load_i) period_q <= sclk_period(speed_i, ratio384_i, mclk_x2_i);
  end

  assign period_o = period_q;
  // low phase takes the extra cycle of an odd period
  assign lo_len_o = period_q - (period_q >> 1);
endmodule

// File: rtl/aud_clk_bitdiv.sv
module aud_clk_bitdiv #(
  parameter int PER_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] lo_len_i,
  output logic             wrap_o,
  output logic             sclk_o,
  output logic             fall_o
);
  logic [PER_W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == period_i - PER_W'(1));
  assign sclk_o = run_i && (cnt_q >= lo_len_i);
  assign fall_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/aud_clk_slotctr.sv
module aud_clk_slotctr #(
  parameter int HALF_SLOTS = 32,
  localparam int SLOTS = 2 * HALF_SLOTS,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic step_i,
  output logic first_o,
  output logic last_o,
  output logic right_o
);
  logic [IDX_W-1:0] idx_q;

  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == IDX_W'(SLOTS - 1));
  assign right_o = run_i && (idx_q >= IDX_W'(HALF_SLOTS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idx_q <= '0;
    else if (!run_i)        idx_q <= '0;
    else if (step_i)        idx_q <= last_o ? '0 : idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/aud_mclk_gen.sv
module aud_mclk_gen
  import aud_mclk_pkg::*;
#(
  parameter int HALF_SLOTS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] speed_i,
  input  logic       ratio384_i,
  input  logic       mclk_x2_i,
  output logic       lrck_o,
  output logic       sclk_o,
  output logic       sclk_fall_o,
  output logic       frame_start_o
);
  logic             run_q;
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] lo_len;
  logic             wrap, fall, first, last, right;
  logic             cfg_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  // config captured at start-up and at frame end only
  assign cfg_load = !run_q || (wrap && last);

  aud_clk_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_load),
    .speed_i    (speed_i),
    .ratio384_i (ratio384_i),
    .mclk_x2_i  (mclk_x2_i),
    .period_o   (period),
    .lo_len_o   (lo_len)
  );

  aud_clk_bitdiv #(.PER_W(PER_W)) u_bitdiv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .period_i (period),
    .lo_len_i (lo_len),
    .wrap_o   (wrap),
    .sclk_o   (sclk_o),
    .fall_o   (fall)
  );

  aud_clk_slotctr #(.HALF_SLOTS(HALF_SLOTS)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .step_i  (wrap),
    .first_o (first),
    .last_o  (last),
    .right_o (right)
  );

  assign lrck_o        = right;
  assign sclk_fall_o   = fall;
  assign frame_start_o = fall && first;
endmodule

// File: rtl/aud_mclk_gen_chk.sv
module aud_mclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lrck_o,
  input logic sclk_o,
  input logic sclk_fall_o,
  input logic frame_start_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !lrck_o && !sclk_o && !sclk_fall_o && !frame_start_o);

  a_r7_lrck_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_o) |-> sclk_fall_o);

  a_r8_fall_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> sclk_fall_o);

  a_r8_strobe_sclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_o |-> !sclk_o);

  a_r8_frame_on_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> sclk_fall_o && !lrck_o);
endmodule

bind aud_mclk_gen aud_mclk_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lrck_o        (lrck_o),
  .sclk_o        (sclk_o),
  .sclk_fall_o   (sclk_fall_o),
  .frame_start_o (frame_start_o)
);

// File: tb/aud_mclk_gen_tb.sv
module aud_mclk_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [1:0] speed_i = 2'b00;
  logic       ratio384_i = 1'b0;
  logic       mclk_x2_i = 1'b0;
  logic       lrck_o, sclk_o, sclk_fall_o, frame_start_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  aud_mclk_gen u_dut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int exp_frame(logic [1:0] s, logic r, logic x);
    int f;
    f = (s == 2'b01) ? 128 : (s == 2'b10) ? 64 : 256;
    if (r) f = f + f / 2;
    if (x || s == 2'b10) f = f * 2;
    return f;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // starting at a negedge where frame_start_o is high, run to the next one
  task automatic measure(string tag, int f, int chg_at, logic [1:0] ns, logic nr, logic nx);
    int len = 0, falls = 0, lr_hi = 0, sc_hi = 0, misal = 0, strb_err = 0;
    int p = f / 64;
    logic pl, ps;
    pl = lrck_o; ps = sclk_o;
    do begin
      if (len == chg_at) begin speed_i = ns; ratio384_i = nr; mclk_x2_i = nx; end
      falls += sclk_fall_o;
      lr_hi += lrck_o;
      sc_hi += sclk_o;
      if (len > 0 && lrck_o != pl && !sclk_fall_o) misal++;
      if (len > 0 && ((ps && !sclk_o) != sclk_fall_o)) strb_err++;
      pl = lrck_o; ps = sclk_o;
      @(negedge clk_i);
      len++;
    end while (!frame_start_o && len < 2000);
    check({tag, " frame length"}, len, f);
    check({"R7 sclk periods ", tag}, falls, 64);
    check({"R7 lrck high cycles ", tag}, lr_hi, 32 * p);
    check({"R6 sclk high cycles ", tag}, sc_hi, 64 * (p / 2));
    check({"R7 lrck edge off fall ", tag}, misal, 0);
    check({"R8 strobe mismatch ", tag}, strb_err, 0);
  endtask

  task automatic wait_fs();
    while (!frame_start_o) @(negedge clk_i);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 reset lrck", lrck_o, 0);
    check("R1 reset sclk", sclk_o, 0);
    check("R1 reset strobes", sclk_fall_o | frame_start_o, 0);

    for (int c = 0; c < 16; c++) begin
      logic [1:0] s;
      logic r, x;
      string tag;
      int f;
      s = c[1:0]; r = c[2]; x = c[3];
      tag = (s == 2'b11) ? "R5" : (x || s == 2'b10) ? "R4" : r ? "R3" : "R2";
      tag = $sformatf("%s s%0d r%0d x%0d", tag, s, r, x);
      f = exp_frame(s, r, x);
      @(negedge clk_i);
      rst_ni = 1'b0;
      speed_i = s; ratio384_i = r; mclk_x2_i = x;
      @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check({"R9 first frame start ", tag}, frame_start_o, 1);
      wait_fs();
      measure(tag, f, -1, s, r, x);
      measure(tag, f, -1, s, r, x);
    end

    // mid-frame change: double 256x -> single 384x
    @(negedge clk_i);
    rst_ni = 1'b0;
    speed_i = 2'b01; ratio384_i = 1'b0; mclk_x2_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    wait_fs();
    measure("R9 old cfg holds", 128, 37, 2'b00, 1'b1, 1'b0);
    measure("R9 new cfg next frame", 384, -1, 2'b00, 1'b1, 1'b0);

    // mid-frame reset
    repeat (100) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 mid-frame reset outputs", {lrck_o, sclk_o, sclk_fall_o, frame_start_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    done = 1;
  end

  initial begin
    wait (done || cyc >= 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule